// File: doc/BRIEF.md
# UART FIFO Control Unit

This block owns the two byte queues of a 16550-style serial port, one for received characters and one for characters waiting to be sent, and interprets writes to the FIFO control register. The receive side is filled by the deserialiser and drained by the host. The transmit side is filled by the host and drained by the serialiser. Both queues present their oldest byte on their data output at all times, so a consumer reads the byte and pulses pop in the same cycle.

A control write can empty either queue in a single cycle. The write acts once and is never stored. A 2-bit field of the same write chooses how many received bytes must be waiting before the receive-trigger output rises for the interrupt logic. The enable bit of the write is stored and passed on to that logic. The shift registers of the serialiser and deserialiser live outside this block, so a flush cannot reach them.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: A control write with bit 1 set empties the receive queue. From the next cycle its count is 0 and its empty flag is high.
- R2: A control write with bit 2 set empties the transmit queue. From the next cycle its count is 0 and its empty flag is high.
- R3: Flushing one queue leaves the count and the stored bytes of the other queue unchanged.
- R4: The flush bits act only in the cycle of the write. A later control write with bits 2:1 clear keeps the bytes already queued, and pushes after a flush are kept.
- R5: Control bits 5:3 have no effect. Writing them changes no count, flag, data output, enable or trigger.
- R6: Control bits 7:6 select the receive trigger level: 00 is 1 byte, 01 is 4, 10 is 8 and 11 is 14. The selection holds until the next control write. rx_trig_o is high exactly while the receive count is at least the selected level.
- R7: Each queue holds 16 bytes. The count runs from 0 to 16, the empty flag is high at 0 and the full flag is high at 16.
- R8: Bytes leave each queue in the order they entered. The oldest byte is shown on the data output while the queue is not empty.
- R9: When a flush and a push hit the same queue in the same cycle, the flush wins and the queue ends empty.
- R10: A push to a full queue is dropped, and a pop from an empty queue changes nothing.
- R11: Control bit 0 is stored and appears on fifo_en_o from the cycle after the write. Reset gives enable 0, trigger code 00 and both queues empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fcr_we_i | input | 1 | Control register write strobe |
| fcr_wdata_i | input | 8 | Control register write data |
| rx_push_i | input | 1 | Push a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | Pop the oldest received byte |
| rx_data_o | output | 8 | Oldest received byte |
| rx_count_o | output | 5 | Receive fill count |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| tx_push_i | input | 1 | Push a byte to send |
| tx_data_i | input | 8 | Byte to send |
| tx_pop_i | input | 1 | Pop the oldest byte to send |
| tx_data_o | output | 8 | Oldest byte to send |
| tx_count_o | output | 5 | Transmit fill count |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| fifo_en_o | output | 1 | Stored FIFO enable bit |
| rx_trig_o | output | 1 | Receive count has reached the selected trigger level |

## Verification
A corrupted pointer shows up at the data outputs on the next pop, because the scoreboard order breaks as soon as the misplaced byte reaches the head of a queue. A bad count shows up one cycle after the push or pop that caused it, in the flags and in rx_trig_o. A stored trigger code that is wrong, or a flush bit that is held instead of pulsed, shows up within one cycle of the next push. The bench watches the count and the trigger output after every single push across all four levels, and it tests that each flush leaves the other queue untouched.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned CNT_W  = PTR_W + 1;

  // control write bit positions
  localparam int unsigned FCR_EN_BIT     = 0;
  localparam int unsigned FCR_RXCLR_BIT  = 1;
  localparam int unsigned FCR_TXCLR_BIT  = 2;
  localparam int unsigned FCR_TRIG_LSB   = 6;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } rx_trig_e;

  function automatic logic [CNT_W-1:0] trig_level(rx_trig_e code);
    case (code)
      TRIG_1:  return CNT_W'(1);
      TRIG_4:  return CNT_W'(4);
      TRIG_8:  return CNT_W'(8);
      default: return CNT_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              push_ok, pop_ok;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      // flush wins over a same-cycle push or pop
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem[rd_ptr_q];
  assign count_o = count_q;

  // R1 and R2 share this check, one instance per queue
  p_flush_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0) && empty_o);
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  p_flush_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && push_i) |=> empty_o);
  p_full_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> $stable(count_o) && full_o);
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> empty_o);
endmodule

// File: rtl/fcr_decode.sv
module fcr_decode
  import uart_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  output logic             rx_flush_o,
  output logic             tx_flush_o,
  output logic             fifo_en_o,
  output logic [CNT_W-1:0] trig_level_o
);
  rx_trig_e trig_q;
  logic     en_q;
  logic     unused_rsvd;

  // flush bits are one-shot: decoded from the write, never stored
  assign rx_flush_o  = we_i && wdata_i[FCR_RXCLR_BIT];
  assign tx_flush_o  = we_i && wdata_i[FCR_TXCLR_BIT];
  assign unused_rsvd = ^wdata_i[5:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      trig_q <= TRIG_1;
    end else if (we_i) begin
      en_q   <= wdata_i[FCR_EN_BIT];
      trig_q <= rx_trig_e'(wdata_i[FCR_TRIG_LSB +: 2]);
    end
  end

  assign fifo_en_o    = en_q;
  assign trig_level_o = trig_level(trig_q);

  p_en_capture_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> fifo_en_o == $past(wdata_i[FCR_EN_BIT]));
  p_level_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(trig_level_o));
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fcr_we_i,
  input  logic [7:0]        fcr_wdata_i,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [CNT_W-1:0]  rx_count_o,
  output logic              rx_empty_o,
  output logic              rx_full_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [CNT_W-1:0]  tx_count_o,
  output logic              tx_empty_o,
  output logic              tx_full_o,
  output logic              fifo_en_o,
  output logic              rx_trig_o
);
  logic             rx_flush, tx_flush;
  logic [CNT_W-1:0] trig_level;

  fcr_decode u_fcr (
    .clk_i, .rst_ni,
    .we_i        (fcr_we_i),
    .wdata_i     (fcr_wdata_i),
    .rx_flush_o  (rx_flush),
    .tx_flush_o  (tx_flush),
    .fifo_en_o   (fifo_en_o),
    .trig_level_o(trig_level)
  );

  byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i(rx_flush),
    .push_i (rx_push_i),
    .data_i (rx_data_i),
    .pop_i  (rx_pop_i),
    .data_o (rx_data_o),
    .count_o(rx_count_o),
    .empty_o(rx_empty_o),
    .full_o (rx_full_o)
  );

  byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i(tx_flush),
    .push_i (tx_push_i),
    .data_i (tx_data_i),
    .pop_i  (tx_pop_i),
    .data_o (tx_data_o),
    .count_o(tx_count_o),
    .empty_o(tx_empty_o),
    .full_o (tx_full_o)
  );

  assign rx_trig_o = (rx_count_o >= trig_level);

  p_trig_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_trig_o |-> !rx_empty_o);
  p_isolate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_we_i && fcr_wdata_i[FCR_RXCLR_BIT] && !fcr_wdata_i[FCR_TXCLR_BIT]
     && !tx_push_i && !tx_pop_i) |=> $stable(tx_count_o));
  p_oneshot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fcr_we_i && rx_push_i && !rx_pop_i && !rx_full_o)
      |=> rx_count_o == $past(rx_count_o) + CNT_W'(1));
endmodule

// File: tb/uart_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fcr_we = 1'b0;
  logic [7:0] fcr_wdata = '0;
  logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_din = '0, tx_din = '0;
  logic [7:0] rx_dout, tx_dout;
  logic [4:0] rx_cnt, tx_cnt;
  logic       rx_empty, rx_full, tx_empty, tx_full, fifo_en, rx_trig;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];
  int exp_lvl = 1;
  logic exp_en = 1'b0;

  always #2.5 clk = ~clk;

  uart_fifo_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fcr_we_i(fcr_we), .fcr_wdata_i(fcr_wdata),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop),
    .rx_data_o(rx_dout), .rx_count_o(rx_cnt), .rx_empty_o(rx_empty), .rx_full_o(rx_full),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop),
    .tx_data_o(tx_dout), .tx_count_o(tx_cnt), .tx_empty_o(tx_empty), .tx_full_o(tx_full),
    .fifo_en_o(fifo_en), .rx_trig_o(rx_trig)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step();
    @(negedge clk);
    fcr_we = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
  endtask

  task automatic fcr_write(logic [7:0] v);
    fcr_we = 1'b1; fcr_wdata = v;
    step();
    if (v[1]) rx_q.delete();
    if (v[2]) tx_q.delete();
    exp_en = v[0];
    case (v[7:6])
      2'b00: exp_lvl = 1;
      2'b01: exp_lvl = 4;
      2'b10: exp_lvl = 8;
      default: exp_lvl = 14;
    endcase
  endtask

  task automatic push_rx(logic [7:0] b);
    rx_push = 1'b1; rx_din = b;
    step();
    if (rx_q.size() < 16) rx_q.push_back(b);
  endtask

  task automatic push_tx(logic [7:0] b);
    tx_push = 1'b1; tx_din = b;
    step();
    if (tx_q.size() < 16) tx_q.push_back(b);
  endtask

  // monitor side: compare head against the scoreboard before popping
  task automatic pop_rx(string req);
    logic [7:0] e;
    if (rx_q.size() > 0) begin
      e = rx_q.pop_front();
      chk(req, int'(rx_dout), int'(e));
    end
    rx_pop = 1'b1;
    step();
  endtask

  task automatic pop_tx(string req);
    logic [7:0] e;
    if (tx_q.size() > 0) begin
      e = tx_q.pop_front();
      chk(req, int'(tx_dout), int'(e));
    end
    tx_pop = 1'b1;
    step();
  endtask

  task automatic chk_counts(string req);
    chk({req, " rx_count"}, int'(rx_cnt), rx_q.size());
    chk({req, " tx_count"}, int'(tx_cnt), tx_q.size());
    chk({req, " rx_empty"}, int'(rx_empty), int'(rx_q.size() == 0));
    chk({req, " tx_empty"}, int'(tx_empty), int'(tx_q.size() == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R11 reset state
    chk_counts("R11 reset");
    chk("R11 reset en", int'(fifo_en), 0);
    chk("R11 reset trig", int'(rx_trig), 0);
    chk("R7 reset full", int'(rx_full | tx_full), 0);

    fcr_write(8'h01);
    chk("R11 enable stored", int'(fifo_en), 1);

    // R8 ordering with default level 1 (R6)
    push_rx(8'hA1); push_rx(8'hB2); push_rx(8'hC3);
    chk_counts("R8 after rx pushes");
    chk("R6 level1 trig", int'(rx_trig), 1);
    for (int i = 0; i < 3; i++) pop_rx("R8 rx order");
    chk_counts("R8 rx drained");

    // R7 fill tx to full, R10 overflow drop
    for (int i = 0; i < 16; i++) push_tx(8'(8'h40 + i));
    chk("R7 tx full", int'(tx_full), 1);
    chk("R7 tx count", int'(tx_cnt), 16);
    push_tx(8'hEE);
    chk("R10 push full dropped", int'(tx_cnt), 16);
    for (int i = 0; i < 16; i++) pop_tx("R8 tx order after drop R10");
    chk_counts("R7 tx empty again");
    pop_tx("R10");
    chk("R10 pop empty count", int'(tx_cnt), 0);
    chk("R10 pop empty flag", int'(tx_empty), 1);
    chk("R10 pop empty full", int'(tx_full), 0);

    // R6 trigger sweep over the four codes
    for (int code = 0; code < 4; code++) begin
      fcr_write(8'((code << 6) | 8'h03));
      chk("R1 flush before sweep", int'(rx_cnt), 0);
      chk("R6 trig at zero", int'(rx_trig), 0);
      for (int n = 1; n <= 15; n++) begin
        push_rx(8'(n + code * 16));
        chk("R6 trig vs level", int'(rx_trig), int'(n >= exp_lvl));
      end
    end
    push_rx(8'h99);
    chk("R7 rx full", int'(rx_full), 1);

    // R3 flush isolation, R1, R2
    for (int i = 0; i < 5; i++) push_tx(8'(8'h70 + i));
    fcr_write(8'h03);
    chk_counts("R1 rx flush R3 tx kept");
    pop_tx("R3 tx head intact");
    for (int i = 0; i < 4; i++) push_rx(8'(8'h20 + i));
    fcr_write(8'h05);
    chk_counts("R2 tx flush R3 rx kept");
    pop_rx("R3 rx head intact");

    // R4 one-shot: write without flush bits keeps bytes
    fcr_write(8'hC1);
    chk_counts("R4 no-flush write keeps");
    step();
    chk_counts("R4 still kept");
    push_rx(8'h5A);
    chk_counts("R4 push after flush kept");

    // R5 reserved bits: level 4, three bytes held
    fcr_write(8'h43);
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    chk("R6 three below four", int'(rx_trig), 0);
    fcr_write(8'h79);
    chk_counts("R5 reserved no effect");
    chk("R5 trig unchanged", int'(rx_trig), 0);
    chk("R5 en unchanged", int'(fifo_en), 1);
    pop_rx("R5 data unchanged");
    push_rx(8'h44); push_rx(8'h55);
    chk("R6 level kept four", int'(rx_trig), 1);

    // R9 flush and push in the same cycle
    fcr_we = 1'b1; fcr_wdata = 8'h02; rx_push = 1'b1; rx_din = 8'hFF;
    step();
    rx_q.delete(); exp_en = 1'b0; exp_lvl = 1;
    chk("R9 flush wins count", int'(rx_cnt), 0);
    chk("R9 flush wins empty", int'(rx_empty), 1);
    chk("R11 enable cleared", int'(fifo_en), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule